// File: doc/BRIEF.md
# High-Speed USB Receive Byte Sequencer

This block sits between a decoded high-speed line and a serial interface engine. It takes one NRZI-decoded bit per strobe of `bit_vld`, along with a line end-of-packet flag and an operating-mode select. It finds the end of the synchronisation pattern and removes stuffed bits. It then packs the remaining bits into bytes and presents them on a UTMI-style receive interface: `rx_active`, `rx_valid`, `rx_error` and `rx_data`.

Byte time is defined by the line, not by the data. Every eight accepted strobes form one byte window. All four outputs change only at the clock edge that accepts the last strobe of a window. Bit unstuffing can leave a window in which no byte was completed. In that window `rx_active` stays high while `rx_valid` is low. This is how the consumer sees the skipped byte time that accumulated stuffed bits create.

The packet sequence runs from waiting for synchronisation, through stripping it, to the data phase (with valid and skipped byte times), to stripping the end of packet. An error path is taken when the run of ones exceeds the stuffing limit outside an end of packet.

Top module: `usbhs_rx_bytes`

## Requirements
- R1: While `rst` is high at a clock edge, `rx_active`, `rx_valid` and `rx_error` are low after that edge, and the window phase restarts so that the 8th strobe after release ends the first window.
- R2: A byte window is 8 strobes of `bit_vld`, counted continuously from reset release in every state. The outputs change only at the edge that accepts the 8th strobe of a window.
- R3: In the idle state, `SYNC_ZEROS` (default 8) consecutive zero bits mark a synchronisation pattern, and any one bit restarts that count. At the first window end at or after detection, `rx_active` goes high with `rx_valid` low.
- R4: After detection, the first one bit closes the synchronisation pattern. The following bits are data, least significant bit first, so patterns of 12 to 32 bits all deliver the same bytes.
- R5: At a window end while active, `rx_valid` is high exactly when a byte was completed during that window, and `rx_data` then carries that byte. Both hold for one byte time.
- R6: With `opmode` = 2'b00 (normal), a zero bit that follows six consecutive ones is discarded. The count of ones starts at zero after the synchronisation pattern. Because of the dropped bits, about one window per 8 stuffed bits shows `rx_active` high and `rx_valid` low.
- R7: With `opmode` other than 2'b00, every bit is kept as data, including runs of ones of any length, and `rx_error` stays low.
- R8: A strobe with `eop_in` high ends the packet, and that bit and later bits are not data. A completed byte still held is presented at the next window end. `rx_active` falls at the first window end with no byte held, and the block returns to idle.
- R9: In normal mode, a one bit after six ones without `eop_in` discards any held byte. `rx_error` is then high with `rx_active` high and `rx_valid` low for exactly one window, starting at the first window end at or after that bit. At the next window end all three outputs are low.
- R10: Every byte value, including the first byte of a packet, is passed through unchanged and in order.
- R11: `rx_valid` is never high while `rx_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Strobe: `bit_in` and `eop_in` carry a line bit this cycle |
| bit_in | input | 1 | NRZI-decoded line bit |
| eop_in | input | 1 | Line end-of-packet indication for the strobed bit |
| opmode | input | 2 | 2'b00 normal (unstuffing on); other values bypass unstuffing |
| rx_active | output | 1 | Packet in progress |
| rx_valid | output | 1 | `rx_data` holds a new byte for this byte time |
| rx_error | output | 1 | Stuffing violation seen; packet aborted |
| rx_data | output | 8 | Received byte |

## Verification
A wrong unstuffing count or byte bit counter shows up as a corrupted or shifted `rx_data` byte at the next window end. It can also show up as a skipped byte time appearing one window early or late. A stuck or mis-entered sequencer state appears as `rx_active` rising or falling one window off, or as `rx_error` lasting zero or two windows. Every such fault becomes visible at the window end that follows the faulty bit, which is at most eight strobes away. The bench compares all outputs every cycle against its own bit-level prediction and checks the byte stream per packet.

// File: rtl/usbhs_rx_pkg.sv
package usbhs_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SYNC  = 3'd1,
        ST_DATA  = 3'd2,
        ST_SKIP  = 3'd3,
        ST_EOP   = 3'd4,
        ST_ERR   = 3'd5,
        ST_ABORT = 3'd6
    } rx_state_e;

    localparam logic [1:0] OPM_NORMAL = 2'b00;

endpackage

// File: rtl/usbhs_rx_phase.sv
module usbhs_rx_phase #(
    parameter int BYTE_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    output logic win_end
);
    localparam int PW = $clog2(BYTE_BITS);
    localparam logic [PW-1:0] LAST = PW'(BYTE_BITS - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        win_end = bit_vld && (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (bit_vld) begin
            cnt_d = win_end ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/usbhs_rx_unstuff.sv
module usbhs_rx_unstuff #(
    parameter int RUN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic bit_in,
    input  logic bypass,
    output logic keep,
    output logic stuffed,
    output logic viol
);
    localparam int OW = $clog2(RUN + 1);
    localparam logic [OW-1:0] RUN_V = OW'(RUN);

    logic [OW-1:0] ones_d, ones_q;
    logic          at_run;

    always_comb begin
        at_run  = (ones_q == RUN_V);
        keep    = en && (bypass || !at_run);
        stuffed = en && !bypass && at_run && !bit_in;
        viol    = en && !bypass && at_run && bit_in;
        ones_d  = ones_q;
        if (clr || bypass || stuffed) ones_d = '0;
        else if (keep)                ones_d = bit_in ? ones_q + 1'b1 : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) ones_q <= '0;
        else     ones_q <= ones_d;
    end
endmodule

// File: rtl/usbhs_rx_shift.sv
module usbhs_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_in,
    output logic         done,
    output logic [W-1:0] byte_o
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  sr_d, sr_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        byte_o = {bit_in, sr_q[W-1:1]};
        done   = shift && (cnt_q == LAST);
        sr_d   = sr_q;
        cnt_d  = cnt_q;
        if (clr) begin
            sr_d  = '0;
            cnt_d = '0;
        end else if (shift) begin
            sr_d  = byte_o;
            cnt_d = done ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else begin
            sr_q  <= sr_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/usbhs_rx_bytes.sv
module usbhs_rx_bytes
    import usbhs_rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SYNC_ZEROS = 8,
    parameter int STUFF_RUN  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              eop_in,
    input  logic [1:0]        opmode,
    output logic              rx_active,
    output logic              rx_valid,
    output logic              rx_error,
    output logic [DATA_W-1:0] rx_data
);
    localparam int ZW = $clog2(SYNC_ZEROS + 1);
    localparam logic [ZW-1:0] ZLAST = ZW'(SYNC_ZEROS - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [ZW-1:0]     zc;
        logic              pend;
        logic [DATA_W-1:0] pbyte;
        logic              act;
        logic              vld;
        logic              err;
        logic [DATA_W-1:0] data;
    } rx_regs_t;

    rx_regs_t q, d;

    logic              win_end;
    logic              in_data;
    logic              us_en, us_keep, us_stuffed, us_viol;
    logic              sh_done;
    logic [DATA_W-1:0] sh_byte;

    assign in_data = (q.st == ST_DATA) || (q.st == ST_SKIP);
    assign us_en   = bit_vld && in_data && !eop_in;

    usbhs_rx_phase #(.BYTE_BITS(DATA_W)) i_phase (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .win_end (win_end)
    );

    usbhs_rx_unstuff #(.RUN(STUFF_RUN)) i_unstuff (
        .clk     (clk),
        .rst     (rst),
        .clr     (!in_data),
        .en      (us_en),
        .bit_in  (bit_in),
        .bypass  (opmode != OPM_NORMAL),
        .keep    (us_keep),
        .stuffed (us_stuffed),
        .viol    (us_viol)
    );

    usbhs_rx_shift #(.W(DATA_W)) i_shift (
        .clk    (clk),
        .rst    (rst),
        .clr    (!in_data),
        .shift  (us_keep),
        .bit_in (bit_in),
        .done   (sh_done),
        .byte_o (sh_byte)
    );

    always_comb begin
        d = q;
        // bit-level progress
        if (bit_vld) begin
            unique case (q.st)
                ST_IDLE: begin
                    if (bit_in)               d.zc = '0;
                    else if (q.zc == ZLAST) begin
                        d.zc = '0;
                        d.st = ST_SYNC;
                    end else                  d.zc = q.zc + 1'b1;
                end
                ST_SYNC: begin
                    if (eop_in)      d.st = ST_EOP;
                    else if (bit_in) d.st = ST_SKIP;
                end
                ST_DATA, ST_SKIP: begin
                    if (eop_in) d.st = ST_EOP;
                    else if (us_viol) begin
                        d.st   = ST_ERR;
                        d.pend = 1'b0;
                    end else if (sh_done) begin
                        d.pend  = 1'b1;
                        d.pbyte = sh_byte;
                    end
                end
                default: ;
            endcase
        end
        // byte-time boundary: update the interface
        if (win_end) begin
            d.err = 1'b0;
            unique case (d.st)
                ST_IDLE: begin
                    d.act = 1'b0;
                    d.vld = 1'b0;
                end
                ST_SYNC: begin
                    d.act = 1'b1;
                    d.vld = 1'b0;
                end
                ST_DATA, ST_SKIP, ST_EOP: begin
                    d.act = d.pend || (d.st != ST_EOP);
                    d.vld = d.pend;
                    if (d.pend) begin
                        d.data = d.pbyte;
                        d.pend = 1'b0;
                        if (d.st != ST_EOP) d.st = ST_DATA;
                    end else begin
                        d.st = (d.st == ST_EOP) ? ST_IDLE : ST_SKIP;
                    end
                end
                ST_ERR: begin
                    d.act = 1'b1;
                    d.vld = 1'b0;
                    d.err = 1'b1;
                    d.st  = ST_ABORT;
                end
                default: begin
                    d.act = 1'b0;
                    d.vld = 1'b0;
                    d.st  = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rx_active = q.act;
    assign rx_valid  = q.vld;
    assign rx_error  = q.err;
    assign rx_data   = q.data;

endmodule

// File: rtl/usbhs_rx_bytes_chk.sv
module usbhs_rx_bytes_chk (
    input logic clk,
    input logic rst,
    input logic win_end,
    input logic rx_active,
    input logic rx_valid,
    input logic rx_error
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rx_active && !rx_valid && !rx_error));

    a_r2_hold_in_window: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> ($stable(rx_active) && $stable(rx_valid) && $stable(rx_error)));

    a_r3_start_without_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_active) |-> !rx_valid);

    a_r9_error_alone: assert property (@(posedge clk) disable iff (rst)
        rx_error |-> (rx_active && !rx_valid));

    a_r9_error_ends_packet: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_error) |-> !rx_active);

    a_r11_valid_in_packet: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rx_active);
endmodule

bind usbhs_rx_bytes usbhs_rx_bytes_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .win_end   (win_end),
    .rx_active (rx_active),
    .rx_valid  (rx_valid),
    .rx_error  (rx_error)
);

// File: tb/test_usbhs_rx_bytes.sv
`timescale 1ns/1ps
module test_usbhs_rx_bytes;
    localparam int SZ = 8;

    logic       clk = 1'b0, rst = 1'b1;
    logic       bit_vld = 1'b0, bit_in = 1'b0, eop_in = 1'b0;
    logic [1:0] opmode = 2'b00;
    logic       rx_active, rx_valid, rx_error;
    logic [7:0] rx_data;

    int n_cmp = 0, n_bad = 0, err_seen = 0, seed_dummy;
    bit sb_on = 1'b0;
    logic [7:0] expq[$];

    usbhs_rx_bytes i_usbhs_rx_bytes (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .eop_in(eop_in),
        .opmode(opmode), .rx_active(rx_active), .rx_valid(rx_valid),
        .rx_error(rx_error), .rx_data(rx_data)
    );

    always #2 clk = ~clk;

    // bit-level prediction built from the requirements
    int m_st = 0, m_ph = 0, m_zc = 0, m_ones = 0, m_cnt = 0;
    bit m_pend = 0, m_we = 0;
    logic [7:0] m_sr = 0, m_pb = 0, e_data = 0;
    logic e_act = 0, e_val = 0, e_err = 0;

    always @(posedge clk) begin
        m_we = 1'b0;
        if (rst) begin
            m_st = 0; m_ph = 0; m_zc = 0; m_pend = 0;
            e_act = 0; e_val = 0; e_err = 0;
        end else if (bit_vld) begin
            m_we = (m_ph == 7);
            m_ph = (m_ph + 1) % 8;
            case (m_st)
                0: if (!bit_in) begin
                       m_zc++;
                       if (m_zc == SZ) begin m_st = 1; m_zc = 0; end
                   end else m_zc = 0;
                1: if (eop_in) m_st = 4;
                   else if (bit_in) begin m_st = 2; m_ones = 0; m_cnt = 0; end
                2: if (eop_in) m_st = 4;
                   else if (opmode == 2'b00 && m_ones == 6) begin
                       if (bit_in) begin m_st = 5; m_pend = 0; end
                       else m_ones = 0;
                   end else begin
                       m_sr = {bit_in, m_sr[7:1]};
                       m_cnt++;
                       m_ones = (bit_in && opmode == 2'b00) ? m_ones + 1 : 0;
                       if (m_cnt == 8) begin m_cnt = 0; m_pend = 1; m_pb = m_sr; end
                   end
                default: ;
            endcase
            if (m_we) begin
                e_err = 0;
                case (m_st)
                    0: begin e_act = 0; e_val = 0; end
                    1: begin e_act = 1; e_val = 0; end
                    2: begin e_act = 1; e_val = m_pend; if (m_pend) e_data = m_pb; m_pend = 0; end
                    4: begin
                           e_act = m_pend; e_val = m_pend;
                           if (m_pend) e_data = m_pb; else m_st = 0;
                           m_pend = 0;
                       end
                    5: begin e_act = 1; e_val = 0; e_err = 1; m_st = 6; end
                    default: begin e_act = 0; e_val = 0; m_st = 0; end
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk(rx_active == e_act, "R3/R8 rx_active", rx_active, e_act);
        chk(rx_valid == e_val, "R2/R5/R6 rx_valid", rx_valid, e_val);
        chk(rx_error == e_err, "R9 rx_error", rx_error, e_err);
        if (e_val) chk(rx_data == e_data, "R5/R10 rx_data", rx_data, e_data);
        chk(!(rx_valid && !rx_active), "R11 valid outside packet", rx_valid, 0);
        if (m_we && rx_error) err_seen++;
        if (m_we && rx_valid && sb_on) begin
            if (expq.size() == 0) chk(1'b0, "R8 extra byte", rx_data, 0);
            else begin
                logic [7:0] e;
                e = expq.pop_front();
                chk(rx_data == e, "R4/R7/R10 byte stream", rx_data, e);
            end
        end
    endtask

    task automatic tick(input bit v, input bit b, input bit e);
        @(negedge clk);
        compare();
        bit_vld = v; bit_in = b; eop_in = e;
    endtask

    task automatic send_bit(input bit b, input bit e);
        if ($urandom % 8 == 0) tick(1'b0, 1'b0, 1'b0);
        tick(1'b1, b, e);
    endtask

    task automatic send_pkt(input int nsync, input int nbytes, input logic [1:0] mode,
                            input bit bad, input bit allff);
        int ones = 0;
        opmode = mode;
        sb_on = !bad;
        err_seen = 0;
        expq.delete();
        repeat (nsync - 1) send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] v;
            v = allff ? 8'hFF : 8'($urandom);
            expq.push_back(v);
            for (int j = 0; j < 8; j++) begin
                send_bit(v[j], 1'b0);
                if (mode == 2'b00) begin
                    ones = v[j] ? ones + 1 : 0;
                    if (ones == 6) begin send_bit(1'b0, 1'b0); ones = 0; end
                end
            end
        end
        repeat (8) send_bit(1'b1, !bad);
        repeat (24) send_bit(1'b1, 1'b0);
        tick(1'b0, 1'b0, 1'b0);
        chk(!rx_active, "R8/R9 packet closed", rx_active, 0);
        if (bad) chk(err_seen == 1, "R9 error windows", err_seen, 1);
        else     chk(expq.size() == 0, "R8 all bytes delivered", expq.size(), 0);
        sb_on = 1'b0;
    endtask

    initial begin
        seed_dummy = $urandom(32'd4711);
        repeat (4) tick(1'b0, 1'b0, 1'b0);
        chk(!rx_active && !rx_valid && !rx_error, "R1 reset state",
            {rx_active, rx_valid, rx_error}, 0);
        rst = 1'b0;
        repeat (10) send_bit(1'b1, 1'b0);
        // shortest and longest synchronisation patterns
        send_pkt(12, 3, 2'b00, 1'b0, 1'b0);
        send_pkt(32, 4, 2'b00, 1'b0, 1'b0);
        // noise: a short zero run broken by a one must not start a packet
        repeat (5) send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        repeat (8) send_bit(1'b1, 1'b0);
        chk(!rx_active, "R3 short zero run ignored", rx_active, 0);
        // dense stuffing, then the same data with unstuffing bypassed
        send_pkt(20, 12, 2'b00, 1'b0, 1'b1);
        send_pkt(20, 12, 2'b01, 1'b0, 1'b1);
        send_pkt(16, 5, 2'b11, 1'b0, 1'b0);
        // stuffing violation
        send_pkt(16, 3, 2'b00, 1'b1, 1'b0);
        // reset in the middle of a packet
        repeat (15) send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        repeat (20) send_bit(1'b0, 1'b1 == 1'b0);
        rst = 1'b1;
        repeat (3) tick(1'b0, 1'b0, 1'b0);
        chk(!rx_active && !rx_valid && !rx_error, "R1 reset mid packet",
            {rx_active, rx_valid, rx_error}, 0);
        rst = 1'b0;
        repeat (10) send_bit(1'b1, 1'b0);
        // random packets
        for (int k = 0; k < 40; k++) begin
            int nsy, nby;
            logic [1:0] md;
            bit bd;
            nsy = 12 + int'($urandom % 21);
            nby = 1 + int'($urandom % 10);
            md  = ($urandom % 4 == 0) ? 2'(1 + $urandom % 3) : 2'b00;
            bd  = (md == 2'b00) && ($urandom % 6 == 0);
            send_pkt(nsy, nby, md, bd, ($urandom % 5 == 0));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=%0d expected=%0d", 150000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule